// File: doc/BRIEF.md
# Master Clock Ratio Detector

This block runs on the master clock of an audio converter. It measures how many master-clock cycles make up one period of the frame clock. The frame clock is the sample-rate clock that toggles once per left/right sample pair. The block then decides which supported oversampling ratio the pair is running at. The supported ratios are 64, 96, 128, 192, 256 and 384 master-clock cycles per frame. A measured period counts as a match when it lies within eight cycles either side of a ratio, so phase wander and jitter between the two clocks are tolerated.

A result is trusted only after two frames in a row give the same ratio. Once trusted, the block reports a ratio code and a locked flag, and it releases the mute request. If a frame matches no permitted ratio, lock is lost at once and the mute request returns. The same happens when the ratio changes, and when the frame clock stops long enough for the cycle counter to saturate.

The set of permitted ratios depends on two inputs. One says whether the stream is in the top (192 kHz) rate band. The other says whether the device is in its register-programmed mode. The rate-band input comes from the surrounding logic.

Top module: `mck_ratio_det`

## Requirements
- R1: The frame clock passes through a two-stage synchronizer. The block measures the number of master-clock cycles between successive rising frame edges. A steady stream of N-cycle frames, with N equal to a permitted ratio, is classified as that ratio.
- R2: A measured period P matches ratio M when M-8 <= P <= M+8, with both ends inclusive. A period of M+9 or M-9 matches no ratio.
- R3: The first rising frame edge after reset only starts the measurement. Lock is declared on the second consecutive measurement that gives the same ratio, and never on the first.
- R4: The ratio code encodes 0=64, 1=96, 2=128, 3=192, 4=256 and 5=384. The code reads 7 whenever the locked flag is low.
- R5: Lock drops on the first measurement that matches no permitted ratio. It also drops on the first measurement that gives a ratio different from the locked one. `auto_mute_o` is high exactly when the locked flag is low.
- R6: With `top_band_i` low, the permitted ratios are 128, 192, 256 and 384. With `top_band_i` high, the permitted ratios are 64, 96, 128 and 192, and 256 and 384 are added only when `prog_mode_i` is high.
- R7: The period counter saturates at 2^CNT_W-1 and does not wrap. A long gap in the frame clock is therefore measured as out of range, even when the gap length modulo 2^CNT_W would fall near a ratio.
- R8: When the period counter reaches saturation, lock drops without waiting for a frame edge.
- R9: After reset the locked flag is low, the ratio code is 7 and the mute request is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| frame_i | input | 1 | Frame clock, asynchronous to `clk_i` |
| prog_mode_i | input | 1 | High when the device is in register-programmed mode |
| top_band_i | input | 1 | High when the stream is in the top (192 kHz) rate band |
| ratio_code_o | output | 3 | Locked ratio code, or 7 when not locked |
| locked_o | output | 1 | Ratio is stable over two consecutive frames |
| auto_mute_o | output | 1 | Mute/shutdown request to the converter |

## Verification
The bench walks periods onto both edges of the tolerance window (M±8) and one cycle beyond (M+9). A design that used an exclusive window, or an asymmetric one, would drop lock or take a wrong ratio there. It switches the band and mode inputs so that 64-cycle frames in the lower bands, and 256-cycle frames in the top band without programmed mode, must be rejected; an unmasked classifier would lock on them. A frame-clock gap of 1280 cycles checks two things. Lock must fall mid-gap. The gap must then measure as invalid, where a wrapping 10-bit counter would read 256 and lock falsely. Ratio changes between two valid ratios check that lock never carries over to a new ratio without two confirming frames.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

   localparam int NUM_RATIOS = 6;

   typedef enum logic [2:0] {
      RC_64   = 3'd0,
      RC_96   = 3'd1,
      RC_128  = 3'd2,
      RC_192  = 3'd3,
      RC_256  = 3'd4,
      RC_384  = 3'd5,
      RC_NONE = 3'd7
   } ratio_code_e;

   // Master-clock cycles per frame for ratio slot idx
   function automatic int unsigned ratio_mult(input int idx);
      case (idx)
         0:       return 64;
         1:       return 96;
         2:       return 128;
         3:       return 192;
         4:       return 256;
         default: return 384;
      endcase
   endfunction

   // Permitted ratio slots for the current band and mode
   function automatic logic [NUM_RATIOS-1:0] allowed_mask(input logic top_band,
                                                          input logic prog_mode);
      if (top_band)
         return prog_mode ? 6'b111111 : 6'b001111;
      return 6'b111100;
   endfunction

endpackage

// File: rtl/mrd_sync_edge.sv
module mrd_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);
   localparam int LAST = STAGES;

   logic [LAST:0] chain_q;

   generate
      for (genvar s = 0; s <= LAST; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[0] <= 1'b0;
               else         chain_q[0] <= async_i;
            end
         end else begin : g_next
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) chain_q[s] <= 1'b0;
               else         chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   assign rise_o = chain_q[LAST-1] & ~chain_q[LAST];

endmodule

// File: rtl/mrd_period_cnt.sv
module mrd_period_cnt #(
   parameter int CNT_W = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             edge_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             sat_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_q <= '0;
      else if (edge_i)
         cnt_q <= CNT_ONE;
      else if (cnt_q != CNT_MAX)
         cnt_q <= cnt_q + CNT_ONE;
   end

   assign cnt_o = cnt_q;
   assign sat_o = (cnt_q == CNT_MAX);

endmodule

// File: rtl/mrd_classifier.sv
module mrd_classifier
   import mrd_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int TOL   = 8
) (
   input  logic [CNT_W-1:0] period_i,
   input  logic             top_band_i,
   input  logic             prog_mode_i,
   output ratio_code_e      code_o
);
   localparam int EXT_W = CNT_W + 1;

   logic [NUM_RATIOS-1:0] allow;
   logic [NUM_RATIOS-1:0] hit;
   logic [EXT_W-1:0]      period_ext;

   assign allow      = allowed_mask(top_band_i, prog_mode_i);
   assign period_ext = {1'b0, period_i};

   generate
      for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_win
         localparam int unsigned MULT = ratio_mult(i);
         localparam logic [EXT_W-1:0] LO = EXT_W'(MULT - TOL);
         localparam logic [EXT_W-1:0] HI = EXT_W'(MULT + TOL);
         assign hit[i] = allow[i] && (period_ext >= LO) && (period_ext <= HI);
      end
   endgenerate

   // Windows are disjoint, so at most one bit of hit is set
   always_comb begin
      code_o = RC_NONE;
      for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
         if (hit[i]) code_o = ratio_code_e'(3'(i));
      end
   end

endmodule

// File: rtl/mrd_lock_ctrl.sv
module mrd_lock_ctrl
   import mrd_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        edge_i,
   input  logic        sat_i,
   input  ratio_code_e class_i,
   output ratio_code_e cand_o,
   output logic        locked_o
);
   logic        have_ref_q;
   ratio_code_e cand_q;
   logic        locked_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         have_ref_q <= 1'b0;
         cand_q     <= RC_NONE;
         locked_q   <= 1'b0;
      end else if (edge_i) begin
         have_ref_q <= 1'b1;
         if (have_ref_q) begin
            if (class_i == RC_NONE) begin
               cand_q   <= RC_NONE;
               locked_q <= 1'b0;
            end else if (class_i == cand_q) begin
               locked_q <= 1'b1;
            end else begin
               cand_q   <= class_i;
               locked_q <= 1'b0;
            end
         end
      end else if (sat_i) begin
         cand_q   <= RC_NONE;
         locked_q <= 1'b0;
      end
   end

   assign cand_o   = cand_q;
   assign locked_o = locked_q;

endmodule

// File: rtl/mck_ratio_det.sv
module mck_ratio_det
   import mrd_pkg::*;
#(
   parameter int CNT_W       = 10,
   parameter int TOL         = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       frame_i,
   input  logic       prog_mode_i,
   input  logic       top_band_i,
   output logic [2:0] ratio_code_o,
   output logic       locked_o,
   output logic       auto_mute_o
);
   localparam int MAX_NEEDED = 384 + TOL;

   generate
      if ((2 ** CNT_W) - 1 <= MAX_NEEDED) begin : g_bad_width
         $error("CNT_W too narrow for the largest ratio window");
      end
      if (TOL < 0 || TOL >= 16) begin : g_bad_tol
         $error("TOL would make ratio windows overlap");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             frame_edge;
   logic [CNT_W-1:0] cnt_q;
   logic             cnt_sat;
   ratio_code_e      class_code;
   ratio_code_e      cand_code;
   logic             locked;

   mrd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (frame_i),
      .rise_o  (frame_edge)
   );

   mrd_period_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .edge_i (frame_edge),
      .cnt_o  (cnt_q),
      .sat_o  (cnt_sat)
   );

   mrd_classifier #(.CNT_W(CNT_W), .TOL(TOL)) u_cls (
      .period_i    (cnt_q),
      .top_band_i  (top_band_i),
      .prog_mode_i (prog_mode_i),
      .code_o      (class_code)
   );

   mrd_lock_ctrl u_lock (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .edge_i   (frame_edge),
      .sat_i    (cnt_sat),
      .class_i  (class_code),
      .cand_o   (cand_code),
      .locked_o (locked)
   );

   assign locked_o     = locked;
   assign ratio_code_o = locked ? cand_code : RC_NONE;
   assign auto_mute_o  = ~locked;

endmodule

// File: rtl/mrd_checker.sv
module mrd_checker #(
   parameter int CNT_W = 10
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             frame_edge,
   input logic             cnt_sat,
   input logic [CNT_W-1:0] cnt_q,
   input logic             top_band_i,
   input logic             prog_mode_i,
   input logic [2:0]       ratio_code_o,
   input logic             locked_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   // R3: lock only rises in the cycle after a frame edge
   p_lock_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(locked_o) |-> $past(frame_edge));

   // R4: a locked code is one of the six defined values
   p_code_legal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      locked_o |-> (ratio_code_o <= 3'd5));

   // R5: lock falls only on a frame measurement or on saturation
   p_unlock_cause_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(locked_o) |-> ($past(frame_edge) || $past(cnt_sat)));

   // R6: top band without programmed mode never locks to 256 or 384
   p_top_mode_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(locked_o) && $past(top_band_i) && (ratio_code_o >= 3'd4))
         |-> $past(prog_mode_i));

   // R6: the lower bands never lock to 64
   p_low_band_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(locked_o) && !$past(top_band_i)) |-> (ratio_code_o != 3'd0));

   // R7: a saturated counter holds until a frame edge
   p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_sat && !frame_edge) |=> (cnt_q == CNT_MAX));

   // R8: saturation removes lock
   p_timeout_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_sat |=> !locked_o);

endmodule

bind mck_ratio_det mrd_checker #(.CNT_W(CNT_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .frame_edge   (frame_edge),
   .cnt_sat      (cnt_sat),
   .cnt_q        (cnt_q),
   .top_band_i   (top_band_i),
   .prog_mode_i  (prog_mode_i),
   .ratio_code_o (ratio_code_o),
   .locked_o     (locked_o)
);

// File: tb/mck_ratio_det_tb.sv
module mck_ratio_det_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame = 1'b0;
   logic       prog = 1'b0;
   logic       top = 1'b0;
   logic [2:0] code;
   logic       locked;
   logic       mute;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   mck_ratio_det u_dut (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .frame_i      (frame),
      .prog_mode_i  (prog),
      .top_band_i   (top),
      .ratio_code_o (code),
      .locked_o     (locked),
      .auto_mute_o  (mute)
   );

   // Scoreboard queues
   int    q_code[$];
   bit    q_lock[$];
   string q_tag[$];
   event  smp_ev;

   // Reference model state, built from the requirements
   bit m_have_ref = 1'b0;
   int m_cand     = 7;
   bit m_locked   = 1'b0;
   int prev_len   = 0;

   function automatic int ref_class(int n, bit tb, bit pm);
      int mult[6] = '{64, 96, 128, 192, 256, 384};
      for (int i = 0; i < 6; i++) begin
         bit ok;
         if (tb) ok = (i <= 3) || pm;
         else    ok = (i >= 2);
         if (ok && n >= mult[i] - 8 && n <= mult[i] + 8) return i;
      end
      return 7;
   endfunction

   task automatic push_exp(string tag);
      q_code.push_back(m_locked ? m_cand : 7);
      q_lock.push_back(m_locked);
      q_tag.push_back(tag);
   endtask

   task automatic model_edge();
      if (m_have_ref) begin
         int c;
         c = ref_class(prev_len, top, prog);
         if (c == 7) begin
            m_cand = 7; m_locked = 1'b0;
         end else if (c == m_cand) begin
            m_locked = 1'b1;
         end else begin
            m_cand = c; m_locked = 1'b0;
         end
      end
      m_have_ref = 1'b1;
   endtask

   // Driver: one frame of len master-clock cycles
   task automatic send_frame(int len, string tag);
      @(negedge clk);
      frame = 1'b1;
      model_edge();
      prev_len = len;
      push_exp(tag);
      repeat (4) @(negedge clk);
      -> smp_ev;
      repeat (len / 2 - 5) @(negedge clk);
      frame = 1'b0;
      if (len >= 1040) begin
         repeat (1035 - len / 2) @(negedge clk);
         m_cand = 7; m_locked = 1'b0;   // R8 timeout mid-gap
         push_exp("R8");
         -> smp_ev;
         repeat (len - 1035) @(negedge clk);
      end else begin
         repeat (len - len / 2) @(negedge clk);
      end
   endtask

   // Monitor: compare on each sample request
   initial begin
      forever begin
         @(smp_ev);
         if (q_code.size() != 0) begin
            int    ec;
            bit    el;
            string tg;
            ec = q_code.pop_front();
            el = q_lock.pop_front();
            tg = q_tag.pop_front();
            n_cmp++;
            if (int'(code) != ec || locked != el || mute != !el) begin
               n_bad++;
               $display("FAIL %s: code=%0d locked=%0d mute=%0d expected code=%0d locked=%0d mute=%0d",
                        tg, code, locked, mute, ec, el, !el);
            end
         end
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      push_exp("R9");
      -> smp_ev;

      // Lower band, automatic mode
      send_frame(256, "R3");
      send_frame(256, "R3");
      send_frame(256, "R1");
      send_frame(264, "R2");
      send_frame(248, "R2");
      send_frame(265, "R2");
      send_frame(256, "R5");
      send_frame(256, "R3");
      send_frame(384, "R3");
      send_frame(384, "R5");
      send_frame(192, "R4");
      send_frame(192, "R5");
      send_frame(64,  "R4");
      send_frame(64,  "R6");

      // Top band
      top = 1'b1;
      send_frame(96,  "R6");
      send_frame(96,  "R4");
      send_frame(128, "R4");
      send_frame(256, "R6");
      send_frame(256, "R6");
      prog = 1'b1;
      send_frame(256, "R6");
      send_frame(56,  "R6");
      send_frame(72,  "R2");
      send_frame(64,  "R2");

      // Frame clock gap, then recovery
      send_frame(1280, "R8");
      send_frame(256,  "R7");
      send_frame(256,  "R7");
      send_frame(256,  "R1");
      repeat (4) @(negedge clk);

      if (q_code.size() != 0) begin
         n_bad++;
         $display("FAIL R1: %0d results pending, expected 0", q_code.size());
      end
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (150000) @(posedge clk);
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule